// File: doc/BRIEF.md
# Factorial Accelerator with Busy Flag

This block is a small memory-mapped engine that computes n! for a 32-bit operand and keeps the low 32 bits of the product. Software starts a run by writing the operand into the value register. While the run lasts, the engine holds off any new operand and shows a busy flag in its status register. When the run ends, the result takes the operand's place in the same value register.

Software can poll the busy flag until it clears. It can instead set an enable bit in the status register, and the block then sends a one-cycle set pulse to the chip's interrupt aggregator at completion. The engine does one 32-bit multiply per clock while it counts the operand down to zero. The run therefore takes n+1 cycles, and the product wraps modulo 2^32 on overflow.

Register offsets: value register at 0x08, status register at 0x20. Status bit 0 is busy (read-only). Status bit 7 is the completion interrupt enable (read/write).

Top module: `fact_accel`

## Requirements
- R1: A 4-byte write to offset 0x08 while the engine is idle loads the written value as the operand. The same write sets the busy flag, which is status bit 0 at offset 0x20.
- R2: A write to offset 0x08 while busy is ignored. The value register and the busy flag are unchanged by it, and the run in progress still yields the factorial of the original operand.
- R3: A 4-byte read of offset 0x08 returns the operand while busy. It returns the result once the busy flag has cleared.
- R4: The result is n×(n−1)×…×1 modulo 2^32. An operand of 0 or 1 gives 1.
- R5: The busy flag reads 1 for exactly n+1 cycles after the cycle of the starting write, and reads 0 from then on.
- R6: A status write changes only the enable bit, bit 7, to the written bit 7. A status read returns busy in bit 0, enable in bit 7, and zero in every other bit. Reset clears both.
- R7: At completion, if the enable bit is 1, `irq_set` is high for exactly one cycle: the first cycle in which busy reads 0. With the enable bit at 0, no pulse is produced.
- R8: An access whose size is not 4 bytes is ignored: a write of that kind changes nothing. Such reads, and 4-byte reads of any offset other than 0x08 and 0x20, return 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (8) | Byte offset of the access |
| acc_size | input | 4 | Access size in bytes; only 4 is accepted |
| acc_wdata | input | DATA_W (32) | Write data |
| acc_rdata | output | DATA_W (32) | Read data, combinational from the current access |
| irq_set | output | 1 | One-cycle completion pulse to the interrupt aggregator |

## Verification
The engine is tried with the operands 0, 1, 3, 4, 5 and 13. The 0 and 1 cases separate a correct empty product from an off-by-one in the countdown. The 3, 4 and 5 cases expose the latency, because the busy flag is counted cycle by cycle against n+1. Operand 13 is the smallest whose factorial wraps, so it shows whether the product is truncated modulo 2^32. A second operand written in the middle of a run, a status write that tries to set bit 0, and 2-byte accesses all show whether the lockout and ignore rules hold. Runs with the enable bit set and cleared show whether the interrupt pulse is gated and whether it lasts one cycle.

// File: rtl/fact_pkg.sv
package fact_pkg;

    localparam int OFS_VALUE   = 'h08;
    localparam int OFS_STATUS  = 'h20;
    localparam int ACC_BYTES   = 4;
    localparam int STAT_BUSY_B = 0;
    localparam int STAT_IE_B   = 7;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_VALUE,
        TGT_STATUS
    } target_e;

    typedef enum logic {
        ENG_IDLE,
        ENG_RUN
    } eng_state_e;

    function automatic logic [7:0] status_byte(input logic busy, input logic ie);
        logic [7:0] s;
        s = '0;
        s[STAT_BUSY_B] = busy;
        s[STAT_IE_B]   = ie;
        return s;
    endfunction

endpackage

// File: rtl/fact_engine.sv
module fact_engine
    import fact_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    output logic              busy,
    output logic              last_step,
    output logic [DATA_W-1:0] value
);

    eng_state_e        state_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] prod_q;

    assign busy      = (state_q == ENG_RUN);
    assign last_step = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
            prod_q  <= '0;
            value   <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        value   <= operand;
                        cnt_q   <= operand;
                        prod_q  <= DATA_W'(1);
                        state_q <= ENG_RUN;
                    end
                end
                ENG_RUN: begin
                    if (cnt_q == '0) begin
                        value   <= prod_q;
                        state_q <= ENG_IDLE;
                    end else begin
                        prod_q <= prod_q * cnt_q;
                        cnt_q  <= cnt_q - DATA_W'(1);
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // R1: an idle start latches the operand and goes busy
    assert_start_loads_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && value == $past(operand)));

    // R5: the countdown steps by one each busy cycle until it reaches zero
    assert_countdown_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_step) |=> (busy && cnt_q == $past(cnt_q) - DATA_W'(1)));

endmodule

// File: rtl/fact_regif.sv
module fact_regif
    import fact_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [3:0]        acc_size,
    input  logic              ie_wbit,
    input  logic              eng_busy,
    input  logic [DATA_W-1:0] eng_value,
    output logic              start_req,
    output logic              irq_en,
    output logic [DATA_W-1:0] rdata
);

    target_e tgt;

    always_comb begin
        tgt = TGT_NONE;
        if (acc_valid && acc_size == 4'(ACC_BYTES)) begin
            if (acc_addr == ADDR_W'(OFS_VALUE))       tgt = TGT_VALUE;
            else if (acc_addr == ADDR_W'(OFS_STATUS)) tgt = TGT_STATUS;
        end
    end

    assign start_req = acc_write && (tgt == TGT_VALUE);

    always_ff @(posedge clk) begin
        if (rst)                               irq_en <= 1'b0;
        else if (acc_write && tgt == TGT_STATUS) irq_en <= ie_wbit;
    end

    always_comb begin
        unique case (tgt)
            TGT_VALUE:  rdata = eng_value;
            TGT_STATUS: rdata = DATA_W'(status_byte(eng_busy, irq_en));
            default:    rdata = '1;
        endcase
    end

    // R8: an access of the wrong size never reaches a register
    assert_size_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_size != 4'(ACC_BYTES)) |-> (!start_req && rdata == '1));

endmodule

// File: rtl/fact_accel.sv
module fact_accel
    import fact_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [3:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              irq_set
);

    logic              start_req;
    logic              irq_en;
    logic              busy;
    logic              last_step;
    logic [DATA_W-1:0] value;

    fact_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .ie_wbit   (acc_wdata[STAT_IE_B]),
        .eng_busy  (busy),
        .eng_value (value),
        .start_req (start_req),
        .irq_en    (irq_en),
        .rdata     (acc_rdata)
    );

    fact_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start_req),
        .operand   (acc_wdata),
        .busy      (busy),
        .last_step (last_step),
        .value     (value)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_set <= 1'b0;
        else     irq_set <= last_step && irq_en;
    end

    // R2: a value write during a run leaves the register untouched
    assert_busy_lockout_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !last_step && start_req) |=> (busy && $stable(value)));

    // R7: the completion pulse lasts one cycle
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> !irq_set);

    // R7: the pulse coincides with the first idle cycle after a run
    assert_irq_at_finish_R7: assert property (@(posedge clk) disable iff (rst)
        irq_set |-> (!busy && $past(busy)));

endmodule

// File: tb/fact_accel_bench.sv
module fact_accel_bench;

    localparam logic [7:0] A_VAL  = 8'h08;
    localparam logic [7:0] A_STAT = 8'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_addr  = '0;
    logic [3:0]  acc_size  = 4'd4;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        irq_set;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit          m_busy = 0;
    bit          m_ie   = 0;
    bit          m_irq  = 0;
    logic [31:0] m_val  = '0;
    logic [31:0] m_res  = '0;
    longint      m_left = 0;

    always #4 clk = ~clk;

    fact_accel u_fact_accel (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .irq_set(irq_set)
    );

    function automatic logic [31:0] ref_fact(input logic [31:0] n);
        logic [31:0] p = 32'd1;
        for (longint k = 1; k <= longint'(n); k++) p = p * 32'(k);
        return p;
    endfunction

    function automatic logic [31:0] ref_read(input logic [7:0] a, input logic [3:0] sz);
        if (sz != 4'd4) return 32'hFFFF_FFFF;
        if (a == A_VAL)  return m_val;
        if (a == A_STAT) return {24'd0, m_ie, 6'd0, m_busy};
        return 32'hFFFF_FFFF;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step(input bit v, input bit w, input logic [7:0] a,
                              input logic [3:0] sz, input logic [31:0] d);
        bit old_busy = m_busy;
        bit old_ie   = m_ie;
        m_irq = 0;
        if (old_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 0;
                m_val  = m_res;
                m_irq  = old_ie;
            end
        end
        if (v && w && sz == 4'd4) begin
            if (a == A_VAL && !old_busy) begin
                m_val  = d;
                m_busy = 1;
                m_left = longint'(d) + 1;
                m_res  = ref_fact(d);
            end else if (a == A_STAT) begin
                m_ie = d[7];
            end
        end
    endtask

    task automatic acc(input bit v, input bit w, input logic [7:0] a,
                       input logic [3:0] sz, input logic [31:0] d, input string tag);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_addr = a; acc_size = sz; acc_wdata = d;
        #1;
        if (v && !w) check(tag, acc_rdata, ref_read(a, sz));
        check("R7 irq_set", {31'd0, irq_set}, {31'd0, m_irq});
        @(posedge clk);
        model_step(v, w, a, sz, d);
    endtask

    // run operand n, poll status and count busy cycles seen at the port
    task automatic run_and_count(input logic [31:0] n, input string tag);
        int seen = 0;
        acc(1, 1, A_VAL, 4, n, "R1");
        for (int i = 0; i < 200; i++) begin
            acc(1, 0, A_STAT, 4, 0, "R5 status poll");
            if (acc_rdata[0]) seen++;
            else break;
        end
        check("R5 busy cycle count", 32'(seen), n + 1);
        acc(1, 0, A_VAL, 4, 0, tag);
        check(tag, acc_rdata, ref_fact(n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R6: reset state of status and value
        acc(1, 0, A_STAT, 4, 0, "R6 reset status");
        acc(1, 0, A_VAL, 4, 0, "R3 reset value");

        // R1/R2/R3/R6: start 5, try to overwrite, enable interrupt mid-run
        acc(1, 1, A_VAL, 4, 5, "R1");
        acc(1, 0, A_STAT, 4, 0, "R1 busy set");
        acc(1, 0, A_VAL, 4, 0, "R3 operand while busy");
        acc(1, 1, A_VAL, 4, 9, "R2");
        acc(1, 0, A_VAL, 4, 0, "R2 operand kept");
        acc(1, 1, A_STAT, 4, 32'h80, "R6");
        acc(1, 0, A_STAT, 4, 0, "R6 busy kept, enable set");
        for (int i = 0; i < 20; i++) acc(0, 0, 0, 4, 0, "R7");
        acc(1, 0, A_VAL, 4, 0, "R4 5! result");
        check("R4 5! literal", acc_rdata, 32'd120);

        // R4/R5/R7: boundary operands with enable set
        run_and_count(0, "R4 0! result");
        run_and_count(1, "R4 1! result");
        run_and_count(4, "R4 4! result");

        // R6: write bit 0 and other bits, clear enable
        acc(1, 1, A_STAT, 4, 32'h7F, "R6");
        acc(1, 0, A_STAT, 4, 0, "R6 only bit 7 written");
        run_and_count(3, "R7 no pulse, R4 3! result");

        // R4: wrap modulo 2^32
        run_and_count(13, "R4 13! wraps");
        check("R4 13! literal", acc_rdata, 32'd1932053504);

        // R8: wrong-size and unmapped accesses
        acc(1, 1, A_VAL, 2, 7, "R8");
        acc(1, 0, A_STAT, 4, 0, "R8 no start from 2-byte write");
        acc(1, 1, A_STAT, 2, 32'h80, "R8");
        acc(1, 0, A_STAT, 4, 0, "R8 enable unchanged");
        acc(1, 0, A_VAL, 2, 0, "R8 2-byte read");
        acc(1, 0, 8'h40, 4, 0, "R8 unmapped read");
        acc(0, 0, 0, 4, 0, "R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule